// File: doc/BRIEF.md
# UART Channel Power-State Controller

This block decides, for each channel of a serial port, whether the channel runs, sleeps or sits in a deeper isolated state. In the running state the channel's baud and receive logic is clocked, and the host register strobes reach the core. In the sleeping state the oscillator request and the clock enable are dropped, but the register strobes still pass, so software can reach the registers. In the isolated state the register strobes are also blocked, so host bus traffic cannot disturb the core.

Software asks for sleep by setting a per-channel enable bit. The channel enters sleep only when that bit is set, the transmitter is empty, the receiver is idle and no interrupt is pending. A shared external pin then moves every sleeping channel into the isolated state. A channel returns to running on an edge on its receive line or on any of its four active-low modem inputs. A channel also returns when the pin is released, which lets software recover if no line activity arrives. After a return, the oscillator request rises at once, and the clock enable follows after a programmable number of cycles, so the restart interval is modelled. A count of zero suits a clock that is supplied externally and kept running.

Top module: `uart_pwr_ctrl`

## Requirements
- R1: After reset every channel is running: state code 00, `osc_on` 1, `clk_en` 1, `bus_iso` 0.
- R2: A running channel with `clk_en` high moves to sleep (state code 01, `osc_on` 0, `clk_en` 0) on the next clock if and only if `sleep_en`, `tx_empty` and `rx_idle` are 1 and `irq_pend` is 0.
- R3: A sleeping channel returns to running on the next clock when any of its four sleep qualifiers stops holding.
- R4: While a channel is not isolated, `core_rd` equals `host_cs & host_rd` and `core_wr` equals `host_cs & host_wr` for that channel, in both running and sleep.
- R5: The isolated state (code 10) is reached only from sleep, one clock after `psave_pin` is 1. A running channel with `psave_pin` at 1 stays running.
- R6: In the isolated state `bus_iso` is 1 and `core_rd` and `core_wr` stay 0 whatever the strobes do. Changes of the sleep qualifiers have no effect there.
- R7: An edge on `rx_line`, `cts_n`, `dsr_n`, `cd_n` or `ri_n` of a sleeping or isolated channel returns that channel to running after the third rising clock edge that follows the edge, and not earlier. The first two of those clock edges are for synchronization.
- R8: Dropping `psave_pin` to 0 returns an isolated channel to running on the next clock, with `bus_iso` back at 0.
- R9: On each return to running, `osc_on` is 1 in the same cycle as the state change. `clk_en` rises exactly N cycles later, where N is `restart_cycles`. When N is 0, `clk_en` rises in that same cycle.
- R10: Channels are independent: one channel's sleep, isolation or wake leaves the other channel's state unchanged.
- R11: A running channel whose `clk_en` is still 0 during a restart does not enter sleep, even with all qualifiers holding.
- R12: The state code per channel is 00 running, 01 sleep, 10 isolated. The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psave_pin | input | 1 | Shared isolation request pin, active high |
| restart_cycles | input | CNT_W | Clock restart delay in cycles |
| sleep_en | input | NCH | Per-channel software sleep request |
| tx_empty | input | NCH | Transmitter empty, per channel |
| rx_idle | input | NCH | Receiver idle, per channel |
| irq_pend | input | NCH | Interrupt pending, per channel |
| rx_line | input | NCH | Serial receive line, per channel |
| cts_n | input | NCH | Clear-to-send modem input, active low |
| dsr_n | input | NCH | Data-set-ready modem input, active low |
| cd_n | input | NCH | Carrier-detect modem input, active low |
| ri_n | input | NCH | Ring-indicator modem input, active low |
| host_cs | input | NCH | Host chip select, per channel |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| core_rd | output | NCH | Read strobe passed to the channel core |
| core_wr | output | NCH | Write strobe passed to the channel core |
| osc_on | output | NCH | Oscillator run request |
| clk_en | output | NCH | Baud and receive clock enable, high once the clock is stable |
| bus_iso | output | NCH | Register bus isolated |
| pwr_state | output | 2*NCH | State code per channel, two bits each |

## Verification
A wrong state register shows up on `pwr_state` and `bus_iso` one clock after the stimulus that should have moved it. A wrong isolation decision appears at once on `core_rd` and `core_wr` for the strobes applied. A mis-set restart counter shows as `clk_en` rising in the wrong cycle after a return to running, which the bench measures cycle by cycle for each delay from 0 to 7. Synchronizer errors show as a wake one cycle early or late, so every wake input is checked at the second and third clock after its edge.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'b00,
        PWR_SLEEP = 2'b01,
        PWR_ISO   = 2'b10
    } pwr_state_e;

    localparam int WAKE_SRC_W = 5;

endpackage

// File: rtl/uart_pwr_wake_det.sv
module uart_pwr_wake_det #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic             wake
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
        logic [WIDTH-1:0]             prev;
    } det_regs_t;

    det_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.stg[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            r_d.stg[i] = r_q.stg[i-1];
        end
        r_d.prev   = r_q.stg[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // any bit differing from its previous synchronized value is an edge
    assign wake = |(r_q.stg[STAGES-1] ^ r_q.prev);

endmodule

// File: rtl/uart_pwr_chan.sv
module uart_pwr_chan
    import uart_pwr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             tx_empty,
    input  logic             rx_idle,
    input  logic             irq_pend,
    input  logic             wake,
    input  logic             psave_pin,
    input  logic [CNT_W-1:0] restart_cycles,
    output pwr_state_e       state,
    output logic             osc_on,
    output logic             clk_en,
    output logic             bus_iso
);

    typedef struct packed {
        pwr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             clk_en;
    } chan_regs_t;

    chan_regs_t r_d, r_q;
    logic       qual_ok;

    always_comb begin
        r_d     = r_q;
        qual_ok = sleep_req && tx_empty && rx_idle && !irq_pend;

        case (r_q.st)
            PWR_RUN: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
                if (qual_ok && r_q.clk_en) begin
                    r_d.st = PWR_SLEEP;
                end
            end
            PWR_SLEEP: begin
                if (wake || !qual_ok) begin
                    r_d.st  = PWR_RUN;
                    r_d.cnt = restart_cycles;
                end else if (psave_pin) begin
                    r_d.st = PWR_ISO;
                end
            end
            PWR_ISO: begin
                if (wake || !psave_pin) begin
                    r_d.st  = PWR_RUN;
                    r_d.cnt = restart_cycles;
                end
            end
            default: begin
                r_d.st  = PWR_RUN;
                r_d.cnt = '0;
            end
        endcase

        r_d.clk_en = (r_d.st == PWR_RUN) && (r_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= PWR_RUN;
            r_q.cnt    <= '0;
            r_q.clk_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state   = r_q.st;
    assign clk_en  = r_q.clk_en;
    assign osc_on  = (r_q.st == PWR_RUN);
    assign bus_iso = (r_q.st == PWR_ISO);

endmodule

// File: rtl/uart_pwr_busgate.sv
module uart_pwr_busgate (
    input  logic cs,
    input  logic rd,
    input  logic wr,
    input  logic iso,
    output logic core_rd,
    output logic core_wr
);

    logic pass;

    always_comb begin
        pass    = cs && !iso;
        core_rd = pass && rd;
        core_wr = pass && wr;
    end

endmodule

// File: rtl/uart_pwr_ctrl.sv
module uart_pwr_ctrl
    import uart_pwr_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psave_pin,
    input  logic [CNT_W-1:0] restart_cycles,
    input  logic [NCH-1:0]   sleep_en,
    input  logic [NCH-1:0]   tx_empty,
    input  logic [NCH-1:0]   rx_idle,
    input  logic [NCH-1:0]   irq_pend,
    input  logic [NCH-1:0]   rx_line,
    input  logic [NCH-1:0]   cts_n,
    input  logic [NCH-1:0]   dsr_n,
    input  logic [NCH-1:0]   cd_n,
    input  logic [NCH-1:0]   ri_n,
    input  logic [NCH-1:0]   host_cs,
    input  logic             host_rd,
    input  logic             host_wr,
    output logic [NCH-1:0]   core_rd,
    output logic [NCH-1:0]   core_wr,
    output logic [NCH-1:0]   osc_on,
    output logic [NCH-1:0]   clk_en,
    output logic [NCH-1:0]   bus_iso,
    output logic [2*NCH-1:0] pwr_state
);

    localparam int STW = $bits(pwr_state_e);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [WAKE_SRC_W-1:0] lines;
        logic                  wake;
        pwr_state_e            st;

        assign lines = {rx_line[g], cts_n[g], dsr_n[g], cd_n[g], ri_n[g]};

        uart_pwr_wake_det #(
            .WIDTH  (WAKE_SRC_W),
            .STAGES (SYNC_STAGES)
        ) u_wake (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (lines),
            .wake     (wake)
        );

        uart_pwr_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk            (clk),
            .rst_n          (rst_n),
            .sleep_req      (sleep_en[g]),
            .tx_empty       (tx_empty[g]),
            .rx_idle        (rx_idle[g]),
            .irq_pend       (irq_pend[g]),
            .wake           (wake),
            .psave_pin      (psave_pin),
            .restart_cycles (restart_cycles),
            .state          (st),
            .osc_on         (osc_on[g]),
            .clk_en         (clk_en[g]),
            .bus_iso        (bus_iso[g])
        );

        uart_pwr_busgate u_gate (
            .cs      (host_cs[g]),
            .rd      (host_rd),
            .wr      (host_wr),
            .iso     (bus_iso[g]),
            .core_rd (core_rd[g]),
            .core_wr (core_wr[g])
        );

        assign pwr_state[STW*g +: STW] = st;
    end

endmodule

// File: rtl/uart_pwr_chk.sv
module uart_pwr_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psave_pin,
    input logic [NCH-1:0]   sleep_en,
    input logic [NCH-1:0]   tx_empty,
    input logic [NCH-1:0]   rx_idle,
    input logic [NCH-1:0]   irq_pend,
    input logic [NCH-1:0]   host_cs,
    input logic             host_rd,
    input logic             host_wr,
    input logic [NCH-1:0]   core_rd,
    input logic [NCH-1:0]   core_wr,
    input logic [NCH-1:0]   osc_on,
    input logic [NCH-1:0]   clk_en,
    input logic [NCH-1:0]   bus_iso,
    input logic [2*NCH-1:0] pwr_state
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R12
        a_r12_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_state[2*g +: 2] != 2'b11);

        // R6
        a_r6_iso_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_state[2*g +: 2] == 2'b10) |-> (bus_iso[g] && !core_rd[g] && !core_wr[g]));

        // R4
        a_r4_strobes_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_state[2*g +: 2] != 2'b10) |->
                ((core_rd[g] == (host_cs[g] && host_rd)) && (core_wr[g] == (host_cs[g] && host_wr))));

        // R5
        a_r5_iso_via_sleep: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwr_state[2*g +: 2] == 2'b10) && ($past(pwr_state[2*g +: 2]) != 2'b10)) |->
                (($past(pwr_state[2*g +: 2]) == 2'b01) && $past(psave_pin)));

        // R2
        a_r2_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwr_state[2*g +: 2] == 2'b01) && ($past(pwr_state[2*g +: 2]) == 2'b00)) |->
                $past(sleep_en[g] && tx_empty[g] && rx_idle[g] && !irq_pend[g] && clk_en[g]));

        // R8
        a_r8_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwr_state[2*g +: 2] == 2'b10) && !psave_pin) |=> (pwr_state[2*g +: 2] == 2'b00));

        // R9
        a_r9_clk_en_running: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[g] |-> (osc_on[g] && (pwr_state[2*g +: 2] == 2'b00)));
    end

endmodule

bind uart_pwr_ctrl uart_pwr_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/uart_pwr_ctrl_tb.sv
module uart_pwr_ctrl_tb;

    localparam int NCH   = 2;
    localparam int CNT_W = 4;
    localparam int CLK_P = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             psave_pin;
    logic [CNT_W-1:0] restart_cycles;
    logic [NCH-1:0]   sleep_en, tx_empty, rx_idle, irq_pend;
    logic [NCH-1:0]   rx_line, cts_n, dsr_n, cd_n, ri_n, host_cs;
    logic             host_rd, host_wr;
    logic [NCH-1:0]   core_rd, core_wr, osc_on, clk_en, bus_iso;
    logic [2*NCH-1:0] pwr_state;

    int n_chk = 0;
    int n_err = 0;

    uart_pwr_ctrl #(.NCH(NCH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .psave_pin(psave_pin), .restart_cycles(restart_cycles),
        .sleep_en(sleep_en), .tx_empty(tx_empty), .rx_idle(rx_idle), .irq_pend(irq_pend),
        .rx_line(rx_line), .cts_n(cts_n), .dsr_n(dsr_n), .cd_n(cd_n), .ri_n(ri_n),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .core_rd(core_rd), .core_wr(core_wr), .osc_on(osc_on), .clk_en(clk_en),
        .bus_iso(bus_iso), .pwr_state(pwr_state)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int st(input int ch);
        return int'(pwr_state[2*ch +: 2]);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tog(input int ch, input int w);
        case (w)
            0: rx_line[ch] = ~rx_line[ch];
            1: cts_n[ch]   = ~cts_n[ch];
            2: dsr_n[ch]   = ~dsr_n[ch];
            3: cd_n[ch]    = ~cd_n[ch];
            default: ri_n[ch] = ~ri_n[ch];
        endcase
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        psave_pin = 0; restart_cycles = '0;
        sleep_en = '0; tx_empty = '1; rx_idle = '1; irq_pend = '0;
        rx_line = '1; cts_n = '1; dsr_n = '1; cd_n = '1; ri_n = '1;
        host_cs = '0; host_rd = 0; host_wr = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int ch = 0; ch < NCH; ch++) begin
            check("R1 state", st(ch), 0);
            check("R1 osc_on", int'(osc_on[ch]), 1);
            check("R1 clk_en", int'(clk_en[ch]), 1);
            check("R1 bus_iso", int'(bus_iso[ch]), 0);
        end

        // R2 sweep of all qualifier combinations, R10 other channel untouched
        for (int ch = 0; ch < NCH; ch++) begin
            for (int i = 0; i < 16; i++) begin
                logic [3:0] v;
                v = 4'(i);
                sleep_en[ch] = v[0]; tx_empty[ch] = v[1]; rx_idle[ch] = v[2]; irq_pend[ch] = v[3];
                cyc(1);
                check("R2 entry", st(ch), (v == 4'b0111) ? 1 : 0);
                check("R2 clk_en", int'(clk_en[ch]), (v == 4'b0111) ? 0 : 1);
                check("R10 other channel", st(1 - ch), 0);
                sleep_en[ch] = 0; tx_empty[ch] = 1; rx_idle[ch] = 1; irq_pend[ch] = 0;
                cyc(1);
                check("R3 back to run", st(ch), 0);
            end
        end

        // R3 each qualifier dropping in sleep
        for (int q = 0; q < 4; q++) begin
            sleep_en[0] = 1;
            cyc(1);
            check("R3 in sleep", st(0), 1);
            case (q)
                0: sleep_en[0] = 0;
                1: tx_empty[0] = 0;
                2: rx_idle[0]  = 0;
                default: irq_pend[0] = 1;
            endcase
            cyc(1);
            check("R3 qualifier drop", st(0), 0);
            sleep_en[0] = 0; tx_empty[0] = 1; rx_idle[0] = 1; irq_pend[0] = 0;
            cyc(1);
        end

        // R4 strobes pass in run and sleep
        for (int ch = 0; ch < NCH; ch++) begin
            for (int m = 0; m < 2; m++) begin
                sleep_en[ch] = (m == 1);
                cyc(1);
                check("R4 mode", st(ch), m);
                for (int s = 0; s < 8; s++) begin
                    host_cs[ch] = s[0]; host_rd = s[1]; host_wr = s[2];
                    #1;
                    check("R4 core_rd", int'(core_rd[ch]), int'(s[0] & s[1]));
                    check("R4 core_wr", int'(core_wr[ch]), int'(s[0] & s[2]));
                end
                host_cs = '0; host_rd = 0; host_wr = 0;
                sleep_en[ch] = 0;
                cyc(1);
            end
        end

        // R5 / R6 / R8 isolation path
        for (int ch = 0; ch < NCH; ch++) begin
            psave_pin = 1;
            cyc(2);
            check("R5 no iso from run", st(ch), 0);
            sleep_en[ch] = 1;
            cyc(1);
            check("R5 sleep first", st(ch), 1);
            cyc(1);
            check("R5 iso", st(ch), 2);
            check("R6 bus_iso", int'(bus_iso[ch]), 1);
            check("R6 osc_on off", int'(osc_on[ch]), 0);
            check("R10 other channel", st(1 - ch), 0);
            for (int s = 0; s < 8; s++) begin
                host_cs[ch] = s[0]; host_rd = s[1]; host_wr = s[2];
                #1;
                check("R6 core_rd blocked", int'(core_rd[ch]), 0);
                check("R6 core_wr blocked", int'(core_wr[ch]), 0);
            end
            host_cs = '0; host_rd = 0; host_wr = 0;
            irq_pend[ch] = 1; sleep_en[ch] = 0;
            cyc(1);
            check("R6 qualifiers ignored", st(ch), 2);
            irq_pend[ch] = 0;
            psave_pin = 0;
            cyc(1);
            check("R8 pin release", st(ch), 0);
            check("R8 bus_iso", int'(bus_iso[ch]), 0);
        end

        // R7 wake from isolated and from sleep, every source
        for (int ch = 0; ch < NCH; ch++) begin
            for (int w = 0; w < 5; w++) begin
                sleep_en[ch] = 1;
                cyc(1);
                psave_pin = 1;
                cyc(1);
                check("R7 iso before wake", st(ch), 2);
                tog(ch, w);
                cyc(2);
                check("R7 not yet awake", st(ch), 2);
                cyc(1);
                check("R7 awake from iso", st(ch), 0);
                check("R10 other channel", st(1 - ch), 0);
                sleep_en[ch] = 0; psave_pin = 0;
                cyc(1);

                sleep_en[ch] = 1;
                cyc(1);
                check("R7 sleep before wake", st(ch), 1);
                tog(ch, w);
                cyc(2);
                check("R7 sleep not yet awake", st(ch), 1);
                cyc(1);
                check("R7 awake from sleep", st(ch), 0);
                sleep_en[ch] = 0;
                cyc(1);
            end
        end

        // R9 restart delay sweep
        for (int ch = 0; ch < NCH; ch++) begin
            for (int n = 0; n < 8; n++) begin
                restart_cycles = CNT_W'(n);
                sleep_en[ch] = 1;
                cyc(1);
                check("R9 asleep", st(ch), 1);
                sleep_en[ch] = 0;
                cyc(1);
                check("R9 run", st(ch), 0);
                check("R9 osc_on", int'(osc_on[ch]), 1);
                check("R9 clk_en at return", int'(clk_en[ch]), (n == 0) ? 1 : 0);
                for (int k = 1; k <= n; k++) begin
                    cyc(1);
                    check("R9 clk_en delay", int'(clk_en[ch]), (k >= n) ? 1 : 0);
                end
            end
        end

        // R11 no sleep entry during restart
        restart_cycles = 4'd3;
        sleep_en[0] = 1;
        cyc(1);
        sleep_en[0] = 0;
        cyc(1);
        check("R11 returned", st(0), 0);
        sleep_en[0] = 1;
        cyc(2);
        check("R11 held in run", st(0), 0);
        check("R11 clk_en low", int'(clk_en[0]), 0);
        cyc(1);
        check("R11 clk_en up", int'(clk_en[0]), 1);
        check("R11 still run", st(0), 0);
        cyc(1);
        check("R11 sleep after stable", st(0), 1);
        sleep_en[0] = 0;
        restart_cycles = '0;
        cyc(1);
        // R12 codes: 00 run, 01 sleep, 10 isolated
        check("R12 final code", st(0), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule